// File: doc/BRIEF.md
# Predicate-Producing Integer Compare Unit

This unit compares two integer operands and returns a single-bit predicate one clock after a request. A request carries two source operands, a family select, an operand-size select and a 3-bit condition code. The plain-compare family tests a relation either on the operands themselves or on their wrapping difference. The relations are signed and unsigned ordering, equality, signed subtraction overflow, the sign of the difference and the even parity of the difference. The AND-test family first combines the operands by bitwise AND. It then tests that value for zero, for its sign, for even population count, or for being non-positive.

Operands are either 64 bits wide or 32 bits wide. In 32-bit mode the sign bit, the overflow position and the parity span all move to the low word, and the upper halves of the sources are ignored. AND-test condition codes with no defined meaning raise an illegal flag and return a zero predicate. The result registers load only when a request is valid, and they keep their value while no request arrives.

Top module: `cmpu_top`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. While `rst_n` is low, `out_valid`, `out_pred` and `out_illegal` are all 0.
- R2: With `req_mode`=0 and `req_cond`=0, the predicate is 1 when `src1 - src2` overflows as a two's-complement subtraction at the selected width.
- R3: With `req_mode`=0, condition 1 gives unsigned `src1 < src2`, condition 2 gives `src1 == src2`, and condition 3 gives unsigned `src1 <= src2`.
- R4: With `req_mode`=0 and `req_cond`=4, the predicate is the sign bit of the wrapping difference `src1 - src2`. When the subtraction overflows, this differs from signed less-than.
- R5: With `req_mode`=0 and `req_cond`=5, the predicate is 1 when the wrapping difference has an even number of one bits over the selected width.
- R6: With `req_mode`=0, condition 6 gives signed `src1 < src2` and condition 7 gives signed `src1 <= src2`, both taken on the operands themselves.
- R7: With `req_mode`=1, let t = `src1 & src2`. Condition 2 gives t == 0, condition 4 gives the sign bit of t, condition 5 gives even population count of t, and condition 7 gives signed t <= 0.
- R8: With `req_mode`=1 and `req_cond` equal to 0, 1, 3 or 6, `out_illegal` is 1 and `out_pred` is 0. With `req_mode`=0, `out_illegal` is always 0.
- R9: `req_size64`=1 selects 64-bit operands with the sign at bit 63. `req_size64`=0 selects bits [31:0], with the sign at bit 31. In 32-bit mode, bits [63:32] of both sources have no effect.
- R10: While `req_valid` is low, `out_pred` and `out_illegal` keep the values they were given by the last valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request qualifier |
| req_mode | input | 1 | 0 = plain compare family, 1 = AND-test family |
| req_size64 | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| req_cond | input | 3 | Condition code |
| req_src1 | input | 64 | First operand |
| req_src2 | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_pred | output | 1 | Predicate result |
| out_illegal | output | 1 | Undefined condition was requested |

## Verification
The cases that are hardest to reach from the ports are the ones uniform random operands almost never produce. These are real signed overflow at the 32-bit boundary while the upper halves carry noise, AND results that are exactly zero, and equal operands. The stimulus draws each operand from a weighted set that includes zero, all ones, the most negative and most positive values at both widths, and small integers. It also forces the second operand to equal or complement the first, and writes random data into the upper word in 32-bit mode. Directed vectors cover minimum-minus-one overflow, where the difference sign and signed less-than disagree, and the hold of the result registers across idle cycles.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int COND_W = 3;
  localparam int NLANES = 2;

  typedef enum logic {
    FAM_CMP = 1'b0,
    FAM_AND = 1'b1
  } fam_e;

  // condition codes shared by both families
  localparam logic [COND_W-1:0] C_OVF  = 3'd0;
  localparam logic [COND_W-1:0] C_ULT  = 3'd1;
  localparam logic [COND_W-1:0] C_EQ   = 3'd2;
  localparam logic [COND_W-1:0] C_ULE  = 3'd3;
  localparam logic [COND_W-1:0] C_SGN  = 3'd4;
  localparam logic [COND_W-1:0] C_PAR  = 3'd5;
  localparam logic [COND_W-1:0] C_SLT  = 3'd6;
  localparam logic [COND_W-1:0] C_SLE  = 3'd7;
endpackage

// File: rtl/cmpu_rst_sync.sv
module cmpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmpu_rel.sv
module cmpu_rel import cmpu_pkg::*; #(
  parameter int W = 64
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [COND_W-1:0] cond,
  output logic              pred
);
  localparam int MSB = W - 1;

  logic [W-1:0] diff;
  logic         ovf;
  logic         ult;
  logic         eq;
  logic         slt;
  logic         even;

  always_comb begin
    diff = a - b;
    ovf  = ((a ^ diff) & (~b ^ diff)) >> MSB != '0;
    ult  = a < b;
    eq   = a == b;
    slt  = $signed(a) < $signed(b);
    even = ~^diff;
  end

  always_comb begin
    unique case (cond)
      C_OVF:   pred = ovf;
      C_ULT:   pred = ult;
      C_EQ:    pred = eq;
      C_ULE:   pred = ult | eq;
      C_SGN:   pred = diff[MSB];
      C_PAR:   pred = even;
      C_SLT:   pred = slt;
      default: pred = slt | eq;
    endcase
  end

  // R2/R4: without overflow the difference sign equals signed less-than
  always_comb begin
    if (!ovf) a_r4_sign_matches_slt: assert (diff[MSB] == slt);
  end

  // R3: a zero difference means the operands are equal
  always_comb begin
    if (diff == '0) a_r3_zero_diff_eq: assert (eq);
  end
endmodule

// File: rtl/cmpu_andtst.sv
module cmpu_andtst import cmpu_pkg::*; #(
  parameter int W = 64
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [COND_W-1:0] cond,
  output logic              pred,
  output logic              illegal
);
  logic [W-1:0] t;
  logic         is_zero;
  logic         neg;

  always_comb begin
    t       = a & b;
    is_zero = t == '0;
    neg     = t[W-1];
  end

  always_comb begin
    pred    = 1'b0;
    illegal = 1'b0;
    unique case (cond)
      C_EQ:    pred = is_zero;
      C_SGN:   pred = neg;
      C_PAR:   pred = ~^t;
      C_SLE:   pred = neg | is_zero;
      default: illegal = 1'b1;
    endcase
  end

  // R7: a negative AND result can never be zero
  always_comb begin
    if (neg) a_r7_neg_nonzero: assert (!is_zero);
  end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top import cmpu_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mode,
  input  logic              req_size64,
  input  logic [COND_W-1:0] req_cond,
  input  logic [DATA_W-1:0] req_src1,
  input  logic [DATA_W-1:0] req_src2,
  output logic              out_valid,
  output logic              out_pred,
  output logic              out_illegal
);
  logic rst_sync_n;

  cmpu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [NLANES-1:0] rel_p;
  logic [NLANES-1:0] and_p;
  logic [NLANES-1:0] and_ill;

  // lane 0 = narrow width, lane 1 = full width
  for (genvar gi = 0; gi < NLANES; gi++) begin : g_lane
    localparam int LW = (gi == 0) ? HALF_W : DATA_W;

    cmpu_rel #(.W(LW)) u_rel (
      .a    (req_src1[LW-1:0]),
      .b    (req_src2[LW-1:0]),
      .cond (req_cond),
      .pred (rel_p[gi])
    );

    cmpu_andtst #(.W(LW)) u_and (
      .a       (req_src1[LW-1:0]),
      .b       (req_src2[LW-1:0]),
      .cond    (req_cond),
      .pred    (and_p[gi]),
      .illegal (and_ill[gi])
    );
  end

  logic lane;
  logic sel_pred;
  logic sel_ill;
  logic valid_d;
  logic pred_d;
  logic ill_d;

  always_comb begin
    lane     = req_size64;
    sel_pred = (req_mode == FAM_AND) ? and_p[lane] : rel_p[lane];
    sel_ill  = (req_mode == FAM_AND) ? and_ill[lane] : 1'b0;
  end

  // next state with explicit load enable
  always_comb begin
    valid_d = req_valid;
    pred_d  = out_pred;
    ill_d   = out_illegal;
    if (req_valid) begin
      pred_d = sel_pred;
      ill_d  = sel_ill;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid   <= 1'b0;
      out_pred    <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_pred    <= pred_d;
      out_illegal <= ill_d;
    end
  end

  // R1: result valid exactly one cycle after a request
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> out_valid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !out_valid);

  // R8: illegal flag forces a zero predicate, never set by plain compares
  a_r8_illegal_zero_pred: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_illegal |-> !out_pred);
  a_r8_cmp_never_illegal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_mode == FAM_CMP) |=> !out_illegal);

  // R10: results hold while idle
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> ($stable(out_pred) && $stable(out_illegal)));
endmodule

// File: tb/sim_cmpu_top.sv
module sim_cmpu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_mode;
  logic        req_size64;
  logic [2:0]  req_cond;
  logic [63:0] req_src1;
  logic [63:0] req_src2;
  logic        out_valid;
  logic        out_pred;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cmpu_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size64(req_size64), .req_cond(req_cond), .req_src1(req_src1),
    .req_src2(req_src2), .out_valid(out_valid), .out_pred(out_pred),
    .out_illegal(out_illegal)
  );

  // returns {illegal, pred}
  function automatic logic [1:0] model(input logic m, input logic s, input logic [2:0] c,
                                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] msk, x, y, d, t, xs, ys;
    int sb;
    logic sx, sy, sd, st, lt, le, ovf;
    msk = s ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    sb  = s ? 63 : 31;
    x = a & msk; y = b & msk;
    d = (x - y) & msk; t = x & y;
    sx = x[sb]; sy = y[sb]; sd = d[sb]; st = t[sb];
    xs = s ? x : {{32{sx}}, x[31:0]};
    ys = s ? y : {{32{sy}}, y[31:0]};
    lt  = $signed(xs) < $signed(ys);
    le  = lt || (x == y);
    ovf = (sx != sy) && (sd != sx);
    if (!m) begin
      case (c)
        3'd0: return {1'b0, ovf};
        3'd1: return {1'b0, x < y};
        3'd2: return {1'b0, x == y};
        3'd3: return {1'b0, x <= y};
        3'd4: return {1'b0, sd};
        3'd5: return {1'b0, ($countones(d) % 2) == 0};
        3'd6: return {1'b0, lt};
        default: return {1'b0, le};
      endcase
    end else begin
      case (c)
        3'd2: return {1'b0, t == 0};
        3'd4: return {1'b0, st};
        3'd5: return {1'b0, ($countones(t) % 2) == 0};
        3'd7: return {1'b0, st || (t == 0)};
        default: return 2'b10;
      endcase
    end
  endfunction

  function automatic string rtag(input logic m, input logic s, input logic [2:0] c);
    string r;
    if (!m) begin
      case (c)
        3'd0: r = "R2";
        3'd1, 3'd2, 3'd3: r = "R3";
        3'd4: r = "R4";
        3'd5: r = "R5";
        default: r = "R6";
      endcase
    end else begin
      r = (c == 3'd2 || c == 3'd4 || c == 3'd5 || c == 3'd7) ? "R7" : "R8";
    end
    if (!s) r = {r, "/R9"};
    return r;
  endfunction

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return {$urandom, 32'h8000_0000};
      5: return {$urandom, 32'h7FFF_FFFF};
      6: return 64'($urandom % 4);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {ill,pred}=%b expected %b", tag, got, exp);
    end
  endtask

  // one request, result checked one cycle later, away from the edge
  task automatic apply(input logic m, input logic s, input logic [2:0] c,
                       input logic [63:0] a, input logic [63:0] b);
    logic [1:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_size64 = s; req_cond = c;
    req_src1 = a; req_src2 = b;
    e = model(m, s, c, a, b);
    @(posedge clk); #2;
    req_valid = 1'b0;
    check({rtag(m, s, c), "/R1 valid"}, {1'b0, out_valid}, 2'b01);
    check(rtag(m, s, c), {out_illegal, out_pred}, e);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 1'b0; req_size64 = 1'b1;
    req_cond = 3'd0; req_src1 = '0; req_src2 = '0;
    #2;
    check("R1 reset state", {out_valid, out_illegal}, 2'b00);
    check("R1 reset pred", {1'b0, out_pred}, 2'b00);
    #21 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 idle after reset", {1'b0, out_valid}, 2'b00);

    // directed corners
    apply(1'b0, 1'b1, 3'd0, 64'h8000_0000_0000_0000, 64'd1);  // R2 overflow
    apply(1'b0, 1'b1, 3'd4, 64'h8000_0000_0000_0000, 64'd1);  // R4 sign 0
    apply(1'b0, 1'b1, 3'd6, 64'h8000_0000_0000_0000, 64'd1);  // R6 lt 1
    apply(1'b0, 1'b0, 3'd0, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_0000_0001); // R9 overflow
    apply(1'b0, 1'b0, 3'd2, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678); // R9 equal low
    apply(1'b0, 1'b1, 3'd5, 64'd7, 64'd4);                    // R5 diff 3: even
    apply(1'b0, 1'b1, 3'd3, 64'd9, 64'd9);                    // R3 ule equal
    apply(1'b1, 1'b1, 3'd2, 64'hF0F0, 64'h0F0F);              // R7 zero
    apply(1'b1, 1'b1, 3'd7, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF); // R7 neg
    apply(1'b1, 1'b0, 3'd4, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_8000_0000); // R9 sign31
    for (int c = 0; c < 8; c++) apply(1'b1, 1'b1, 3'(c), 64'hFFFF, 64'hFFFF);  // R8

    // R10: outputs hold while idle, even with inputs changing
    apply(1'b1, 1'b1, 3'd6, 64'd1, 64'd1);
    held = {out_illegal, out_pred};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_mode = 1'b0; req_cond = 3'd2; req_src1 = 64'd5; req_src2 = 64'd5;
      @(posedge clk); #2;
      check("R10 hold", {out_illegal, out_pred}, held);
      check("R1 no valid when idle", {1'b0, out_valid}, 2'b00);
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      logic m, s;
      a = pick();
      case ($urandom % 4)
        0: b = a;
        1: b = ~a;
        default: b = pick();
      endcase
      m = 1'($urandom);
      s = 1'($urandom);
      apply(m, s, 3'($urandom), a, b);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule